// File: doc/BRIEF.md
# CMOS RAM Region Lock Controller

This block owns a small battery-backed configuration RAM that two masters share: a host bus port and an embedded microcontroller port. The lower half of the RAM is always open. The upper half is split into four windows, and each window has its own protection bit in a lock register. While a window's bit is set, both ports are refused any read or write into it. A refused read returns an all-ones byte and a refused write leaves the RAM as it was. In both cases the requesting port gets a one-cycle error pulse.

The lock register is reached on either port by raising that port's configuration-select input instead of addressing the RAM. Software can set lock bits but can never clear them. Only a synchronous power-on reset, a standby-supply-loss event or a hard-reset event returns them to zero. The very last RAM byte is outside every window and stays reachable at all times. The two ports share one single-ported array. The host port wins any same-cycle conflict, and the microcontroller port waits on a ready signal.

Top module: `cmos_lock_guard`

## Requirements
- R1: After `rst_n` is held low, a read of the lock register returns 0x00. Both error outputs and both read-valid outputs are low.
- R2: A configuration write ORs data bits 3..0 into the lock bits, so a 1 sets a bit and a 0 leaves it as it was. Bits 7..4 of a lock register read are always 0.
- R3: A cycle with `stby_lost` high or `hard_rst` high clears every lock bit, and so does a cycle with `rst_n` low. The cleared value is visible to the next access.
- R4: Lock bit k (k = 0..3) covers the addresses 0x80+0x20·k to 0x9F+0x20·k. The one exception is bit 3, whose window ends at 0xFE. An address in a window whose bit is clear is accessed normally.
- R5: Address 0xFF is never refused, whatever the lock state.
- R6: Addresses 0x00 to 0x7F are never refused, whatever the lock state.
- R7: A refused read returns 0xFF with read-valid high. A refused write does not change the RAM. Both kinds of refusal raise the port's error output for one cycle.
- R8: Locking applies the same way to the host port and to the microcontroller port.
- R9: While `h_req` is high, `m_ready` is low and a microcontroller request is held off. The held request is served in the first cycle in which the host is idle. The two read-valid outputs are never high together.
- R10: Read data, read-valid and error appear in the cycle after the cycle in which the request is accepted. Writes raise no read-valid.
- R11: A permitted write followed by a permitted read of the same address, from either port, returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| stby_lost | input | 1 | Standby-supply-loss event; clears the locks |
| hard_rst | input | 1 | Hard-reset event; clears the locks |
| h_req | input | 1 | Host request |
| h_cfg | input | 1 | Host access targets the lock register |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 8 | Host RAM address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| h_rvalid | output | 1 | Host read data valid |
| h_err | output | 1 | Host access refused |
| m_req | input | 1 | Microcontroller request |
| m_cfg | input | 1 | Microcontroller access targets the lock register |
| m_we | input | 1 | Microcontroller write (1) or read (0) |
| m_addr | input | 8 | Microcontroller RAM address |
| m_wdata | input | 8 | Microcontroller write data |
| m_ready | output | 1 | Microcontroller request can be accepted this cycle |
| m_rdata | output | 8 | Microcontroller read data |
| m_rvalid | output | 1 | Microcontroller read data valid |
| m_err | output | 1 | Microcontroller access refused |

## Verification
A lock bit stuck at 1 shows up on the next access to its window: the read returns 0xFF with an error pulse one cycle after acceptance, instead of the stored byte. A lock bit that is lost or cleared by mistake shows up as stored data read back from a window that should be refused. It also shows up on the next lock register read, which is compared in full, reserved bits included. A wrong window boundary is caught because the bench probes the first and last address of every window, together with 0x7F and 0xFF. A blocked write that reaches the array anyway is caught by reading the same address back after the locks are cleared.

// File: rtl/cmos_lock_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the CMOS RAM region lock controller.
// Assumes: at most one access is accepted per cycle.
package cmos_lock_pkg;

    // Which port owns the access accepted in a given cycle
    typedef enum logic [1:0] {
        GNT_NONE = 2'd0,
        GNT_HOST = 2'd1,
        GNT_MCU  = 2'd2
    } grant_e;

endpackage

// File: rtl/cmos_lock_reg.sv
`timescale 1ns/1ps
// Module: cmos_lock_reg
// Holds the set-only lock bits. A set request ORs new bits in. Only reset
// or a clear event brings the bits back to zero.
// Assumes: clr is already the OR of all clearing events.
module cmos_lock_reg #(
    parameter int NUM_LOCKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 set_en,
    input  logic [NUM_LOCKS-1:0] set_bits,
    output logic [NUM_LOCKS-1:0] locks
);

    // Sticky lock state: OR-in on set, zero on reset or clear event
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            locks <= '0;
        end else if (set_en) begin
            locks <= locks | set_bits;
        end
    end

endmodule

// File: rtl/cmos_region_decode.sv
`timescale 1ns/1ps
// Module: cmos_region_decode
// Combinational check of whether an address falls into a locked window. The
// upper half of the address space is cut into NUM_LOCKS equal windows. The
// last window stops one short of the top address, which stays open.
// Assumes: NUM_LOCKS is a power of two that divides the upper half evenly.
module cmos_region_decode #(
    parameter int ADDR_W    = 8,
    parameter int NUM_LOCKS = 4
) (
    input  logic [NUM_LOCKS-1:0] locks,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 blocked
);

    localparam int HALF   = 2 ** (ADDR_W - 1);
    localparam int TOP    = 2 ** ADDR_W - 1;
    localparam int WIN_SZ = HALF / NUM_LOCKS;

    logic [NUM_LOCKS-1:0] hit;

    // One window comparator per lock bit
    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
        localparam int BASE = HALF + i * WIN_SZ;
        localparam int LAST = (i == NUM_LOCKS - 1) ? TOP - 1 : BASE + WIN_SZ - 1;
        assign hit[i] = locks[i] && (addr >= ADDR_W'(BASE)) && (addr <= ADDR_W'(LAST));
    end

    // Refuse when any enabled window covers the address
    always_comb begin
        blocked = |hit;
    end

endmodule

// File: rtl/cmos_ram.sv
`timescale 1ns/1ps
// Module: cmos_ram
// Single-port synchronous RAM with registered read data. The array itself
// has no reset, since it models battery-backed contents.
// Assumes: we and re are never high together.
module cmos_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port and registered read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/cmos_lock_guard.sv
`timescale 1ns/1ps
// Module: cmos_lock_guard (top)
// Two-port guarded access to the configuration RAM. The host has fixed
// priority. Each accepted access is checked against the lock windows, and the
// response (data, valid, error) comes back one cycle later on the port that
// owns it.
// Assumes: synchronous active-low reset; a port's request inputs stay stable
// while that request waits for acceptance.
module cmos_lock_guard
    import cmos_lock_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter int              NUM_LOCKS = 4,
    parameter logic [DATA_W-1:0] FILL    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_lost,
    input  logic              hard_rst,
    input  logic              h_req,
    input  logic              h_cfg,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_rvalid,
    output logic              h_err,
    input  logic              m_req,
    input  logic              m_cfg,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_ready,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_rvalid,
    output logic              m_err
);

    logic                 acc;
    logic                 sel_cfg;
    logic                 sel_we;
    logic [ADDR_W-1:0]    sel_addr;
    logic [DATA_W-1:0]    sel_wdata;
    grant_e               gnt_d;
    logic                 blocked;
    logic [NUM_LOCKS-1:0] lock_q;
    logic [DATA_W-1:0]    ram_rdata;
    logic                 ram_we;
    logic                 ram_re;

    grant_e               gnt_q;
    logic                 rd_q;
    logic                 blk_q;
    logic                 cfg_q;
    logic [DATA_W-1:0]    cfg_data_q;
    logic [DATA_W-1:0]    resp_data;

    // Fixed-priority grant: the host always wins, the microcontroller waits
    always_comb begin
        m_ready   = !h_req;
        acc       = h_req || m_req;
        gnt_d     = h_req ? GNT_HOST : (m_req ? GNT_MCU : GNT_NONE);
        sel_cfg   = h_req ? h_cfg   : m_cfg;
        sel_we    = h_req ? h_we    : m_we;
        sel_addr  = h_req ? h_addr  : m_addr;
        sel_wdata = h_req ? h_wdata : m_wdata;
    end

    cmos_lock_reg #(
        .NUM_LOCKS (NUM_LOCKS)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (stby_lost || hard_rst),
        .set_en   (acc && sel_cfg && sel_we),
        .set_bits (sel_wdata[NUM_LOCKS-1:0]),
        .locks    (lock_q)
    );

    cmos_region_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_LOCKS (NUM_LOCKS)
    ) u_dec (
        .locks   (lock_q),
        .addr    (sel_addr),
        .blocked (blocked)
    );

    // RAM strobes, gated by the lock decode
    always_comb begin
        ram_we = acc && !sel_cfg &&  sel_we && !blocked;
        ram_re = acc && !sel_cfg && !sel_we && !blocked;
    end

    cmos_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (ram_rdata)
    );

    // Response bookkeeping for the access accepted this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q      <= GNT_NONE;
            rd_q       <= 1'b0;
            blk_q      <= 1'b0;
            cfg_q      <= 1'b0;
            cfg_data_q <= '0;
        end else begin
            gnt_q      <= gnt_d;
            rd_q       <= acc && !sel_we;
            blk_q      <= acc && !sel_cfg && blocked;
            cfg_q      <= acc && sel_cfg;
            cfg_data_q <= DATA_W'(lock_q);
        end
    end

    // Route the response to the port that owns it
    always_comb begin
        resp_data = blk_q ? FILL : (cfg_q ? cfg_data_q : ram_rdata);
        h_rvalid  = (gnt_q == GNT_HOST) && rd_q;
        m_rvalid  = (gnt_q == GNT_MCU)  && rd_q;
        h_err     = (gnt_q == GNT_HOST) && blk_q;
        m_err     = (gnt_q == GNT_MCU)  && blk_q;
        h_rdata   = h_rvalid ? resp_data : '0;
        m_rdata   = m_rvalid ? resp_data : '0;
    end

endmodule

// File: rtl/cmos_lock_chk.sv
`timescale 1ns/1ps
// Module: cmos_lock_chk
// Property checker for cmos_lock_guard, attached with bind below.
// Assumes: the same clock and synchronous active-low reset as the guard.
module cmos_lock_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_LOCKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 stby_lost,
    input logic                 hard_rst,
    input logic                 h_req,
    input logic                 h_cfg,
    input logic [ADDR_W-1:0]    h_addr,
    input logic [DATA_W-1:0]    h_rdata,
    input logic                 h_rvalid,
    input logic                 h_err,
    input logic                 m_rvalid,
    input logic [NUM_LOCKS-1:0] lock_q
);

    // R2
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stby_lost) && !$past(hard_rst))
            |-> ((lock_q & $past(lock_q)) == $past(lock_q)));

    // R3
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_lost || hard_rst) |=> (lock_q == '0));

    // R5
    top_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_cfg && (h_addr == '1)) |=> !h_err);

    // R6
    low_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_cfg && !h_addr[ADDR_W-1]) |=> !h_err);

    // R7
    blocked_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rvalid && h_err) |-> (h_rdata == '1));

    // R9
    single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_rvalid && m_rvalid));

    // R10
    err_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_err |-> $past(h_req));

endmodule

bind cmos_lock_guard cmos_lock_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_LOCKS (NUM_LOCKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_lost (stby_lost),
    .hard_rst  (hard_rst),
    .h_req     (h_req),
    .h_cfg     (h_cfg),
    .h_addr    (h_addr),
    .h_rdata   (h_rdata),
    .h_rvalid  (h_rvalid),
    .h_err     (h_err),
    .m_rvalid  (m_rvalid),
    .lock_q    (lock_q)
);

// File: tb/tb_cmos_lock_guard.sv
`timescale 1ns/1ps
// Bench: directed scenarios for cmos_lock_guard, one task per scenario.
module tb_cmos_lock_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stby_lost = 1'b0;
    logic       hard_rst = 1'b0;
    logic       h_req = 1'b0, h_cfg = 1'b0, h_we = 1'b0;
    logic [7:0] h_addr = '0, h_wdata = '0;
    logic [7:0] h_rdata;
    logic       h_rvalid, h_err;
    logic       m_req = 1'b0, m_cfg = 1'b0, m_we = 1'b0;
    logic [7:0] m_addr = '0, m_wdata = '0;
    logic       m_ready;
    logic [7:0] m_rdata;
    logic       m_rvalid, m_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cmos_lock_guard dut (
        .clk(clk), .rst_n(rst_n), .stby_lost(stby_lost), .hard_rst(hard_rst),
        .h_req(h_req), .h_cfg(h_cfg), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_err(h_err),
        .m_req(m_req), .m_cfg(m_cfg), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata), .m_rvalid(m_rvalid), .m_err(m_err)
    );

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One host access; returns what the port shows the cycle after acceptance
    task automatic host_op(input logic cfg, input logic we, input logic [7:0] a,
                           input logic [7:0] d, output logic [7:0] rd,
                           output logic v, output logic e);
        @(negedge clk);
        h_req = 1'b1; h_cfg = cfg; h_we = we; h_addr = a; h_wdata = d;
        @(negedge clk);
        rd = h_rdata; v = h_rvalid; e = h_err;
        h_req = 1'b0; h_cfg = 1'b0; h_we = 1'b0;
    endtask

    // One microcontroller access; waits on m_ready
    task automatic mcu_op(input logic cfg, input logic we, input logic [7:0] a,
                          input logic [7:0] d, output logic [7:0] rd,
                          output logic v, output logic e);
        @(negedge clk);
        m_req = 1'b1; m_cfg = cfg; m_we = we; m_addr = a; m_wdata = d;
        while (!m_ready) @(negedge clk);
        @(negedge clk);
        rd = m_rdata; v = m_rvalid; e = m_err;
        m_req = 1'b0; m_cfg = 1'b0; m_we = 1'b0;
    endtask

    task automatic pulse_clear(input bit use_stby);
        @(negedge clk);
        if (use_stby) stby_lost = 1'b1; else hard_rst = 1'b1;
        @(negedge clk);
        stby_lost = 1'b0; hard_rst = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] rd; logic v, e;
        check("R1 h_err after reset", {7'd0, h_err}, 8'd0);
        check("R1 m_err after reset", {7'd0, m_err}, 8'd0);
        check("R1 rvalid after reset", {6'd0, h_rvalid, m_rvalid}, 8'd0);
        host_op(1'b1, 1'b0, 8'h00, 8'h00, rd, v, e);
        check("R1 lock reg reset value", rd, 8'h00);
    endtask

    task automatic t_fill_and_read;
        logic [7:0] rd; logic v, e;
        logic [7:0] list [11] = '{8'h00, 8'h7F, 8'h80, 8'h9F, 8'hA0, 8'hBF,
                                  8'hC0, 8'hDF, 8'hE0, 8'hFE, 8'hFF};
        foreach (list[i]) begin
            host_op(1'b0, 1'b1, list[i], pat(list[i]), rd, v, e);
            check("R10 write raises no rvalid", {6'd0, v, e}, 8'd0);
        end
        foreach (list[i]) begin
            mcu_op(1'b0, 1'b0, list[i], 8'h00, rd, v, e);
            check("R11 mcu readback", rd, pat(list[i]));
            check("R10 mcu rvalid", {7'd0, v}, 8'd1);
        end
    endtask

    task automatic t_lock_window0;
        logic [7:0] rd; logic v, e;
        host_op(1'b1, 1'b1, 8'h00, 8'hF1, rd, v, e);
        host_op(1'b1, 1'b0, 8'h00, 8'h00, rd, v, e);
        check("R2 set bit0, reserved read 0", rd, 8'h01);
        mcu_op(1'b1, 1'b1, 8'h00, 8'h00, rd, v, e);
        host_op(1'b1, 1'b0, 8'h00, 8'h00, rd, v, e);
        check("R2 writing 0 does not clear", rd, 8'h01);
        host_op(1'b0, 1'b0, 8'h80, 8'h00, rd, v, e);
        check("R7 host blocked read data", rd, 8'hFF);
        check("R7 host blocked read err", {6'd0, v, e}, 8'd3);
        mcu_op(1'b0, 1'b0, 8'h9F, 8'h00, rd, v, e);
        check("R8 mcu blocked read data", rd, 8'hFF);
        check("R8 mcu blocked err", {7'd0, e}, 8'd1);
        host_op(1'b0, 1'b1, 8'h80, 8'h33, rd, v, e);
        check("R7 blocked write err", {6'd0, v, e}, 8'd1);
        mcu_op(1'b0, 1'b1, 8'h9F, 8'h44, rd, v, e);
        check("R8 mcu blocked write err", {7'd0, e}, 8'd1);
        host_op(1'b0, 1'b0, 8'hA0, 8'h00, rd, v, e);
        check("R4 unlocked window 1 readable", rd, pat(8'hA0));
        check("R4 no err in unlocked window", {7'd0, e}, 8'd0);
    endtask

    task automatic t_lock_all;
        logic [7:0] rd; logic v, e;
        host_op(1'b1, 1'b1, 8'h00, 8'h0E, rd, v, e);
        mcu_op(1'b1, 1'b0, 8'h00, 8'h00, rd, v, e);
        check("R2 all locks set", rd, 8'h0F);
        host_op(1'b0, 1'b0, 8'hBF, 8'h00, rd, v, e);
        check("R4 window1 end blocked", rd, 8'hFF);
        mcu_op(1'b0, 1'b0, 8'hC0, 8'h00, rd, v, e);
        check("R4 window2 start blocked", {7'd0, e}, 8'd1);
        host_op(1'b0, 1'b0, 8'hE0, 8'h00, rd, v, e);
        check("R4 window3 start blocked", {7'd0, e}, 8'd1);
        host_op(1'b0, 1'b0, 8'hFE, 8'h00, rd, v, e);
        check("R4 window3 end blocked", rd, 8'hFF);
        host_op(1'b0, 1'b0, 8'hFF, 8'h00, rd, v, e);
        check("R5 top byte open (host)", rd, pat(8'hFF));
        mcu_op(1'b0, 1'b0, 8'hFF, 8'h00, rd, v, e);
        check("R5 top byte no err (mcu)", {7'd0, e}, 8'd0);
        host_op(1'b0, 1'b0, 8'h7F, 8'h00, rd, v, e);
        check("R6 low half open", rd, pat(8'h7F));
        mcu_op(1'b0, 1'b1, 8'h00, 8'hC3, rd, v, e);
        host_op(1'b0, 1'b0, 8'h00, 8'h00, rd, v, e);
        check("R6 low half writable while locked", rd, 8'hC3);
    endtask

    task automatic t_clear_events;
        logic [7:0] rd; logic v, e;
        pulse_clear(1'b1);
        host_op(1'b1, 1'b0, 8'h00, 8'h00, rd, v, e);
        check("R3 standby loss clears locks", rd, 8'h00);
        host_op(1'b0, 1'b0, 8'h80, 8'h00, rd, v, e);
        check("R7 blocked host write left RAM", rd, pat(8'h80));
        mcu_op(1'b0, 1'b0, 8'h9F, 8'h00, rd, v, e);
        check("R7 blocked mcu write left RAM", rd, pat(8'h9F));
        host_op(1'b1, 1'b1, 8'h00, 8'h05, rd, v, e);
        pulse_clear(1'b0);
        mcu_op(1'b1, 1'b0, 8'h00, 8'h00, rd, v, e);
        check("R3 hard reset clears locks", rd, 8'h00);
        host_op(1'b1, 1'b1, 8'h00, 8'h08, rd, v, e);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        host_op(1'b1, 1'b0, 8'h00, 8'h00, rd, v, e);
        check("R3 power-on reset clears locks", rd, 8'h00);
    endtask

    task automatic t_contention;
        @(negedge clk);
        h_req = 1'b1; h_cfg = 1'b0; h_we = 1'b0; h_addr = 8'h7F;
        m_req = 1'b1; m_cfg = 1'b0; m_we = 1'b0; m_addr = 8'hA0;
        #0.5;
        check("R9 mcu stalled while host requests", {7'd0, m_ready}, 8'd0);
        @(negedge clk);
        check("R9 host served first", h_rdata, pat(8'h7F));
        check("R9 no mcu response yet", {7'd0, m_rvalid}, 8'd0);
        h_req = 1'b0;
        #0.5;
        check("R9 mcu ready once host idle", {7'd0, m_ready}, 8'd1);
        @(negedge clk);
        check("R9 held mcu request served", m_rdata, pat(8'hA0));
        check("R9 host response gone", {7'd0, h_rvalid}, 8'd0);
        m_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_and_read();
        t_lock_window0();
        t_lock_all();
        t_clear_events();
        t_contention();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule